// File: doc/BRIEF.md
# Graceful Transmit Stop Controller

This controller sits between a transmit frame scheduler and a MAC transmit engine and turns a software pause request into a clean halt at a frame boundary. It never truncates a frame. If a frame is on the wire when the pause is requested, the frame is allowed to run until it ends normally or ends through a collision abort. Only then does the controller report that the pause has been reached.

While the pause request is held, the transmit engine gets no permission to begin a new frame. When software drops the request, permission returns, and the engine starts the next queued frame from its first byte; a frame cut short by a collision is not resumed partway through. The controller's only outputs are a start-permit level and a single-cycle stop-complete event meant for an interrupt status register. Serialization is handled downstream and shifts each byte least significant bit first; it is not part of this block.

Top module: `gts_ctrl`

## Requirements
- R1: After reset the controller is running: `stop_done` is 0, and `start_permit` is 1 whenever `frame_ready` is 1, `tx_busy` is 0 and `stop_req` is 0.
- R2: If `stop_req` is sampled high while `tx_busy` is 0, `stop_done` is 1 in the cycle that follows that clock edge.
- R3: While `stop_req` is high and a frame is in progress (`tx_busy` 1, no end strobe), `stop_done` stays 0 and `start_permit` stays 0.
- R4: A pending stop completes on a normal frame end: `stop_done` is 1 in the cycle after the clock edge that samples `tx_eof` high.
- R5: A pending stop also completes when the frame ends by collision: `stop_done` is 1 in the cycle after the clock edge that samples `tx_col_abort` high.
- R6: `stop_done` lasts exactly one cycle and occurs at most once for each continuous assertion of `stop_req`.
- R7: If `stop_req` is cleared before the in-flight frame ends, no `stop_done` is issued and `start_permit` follows `frame_ready` again once the frame is over.
- R8: `start_permit` is 0 in any cycle in which `stop_req` is 1, including the first cycle of a new request while `frame_ready` is 1.
- R9: After a completed stop, clearing `stop_req` makes `start_permit` return to 1 (given `frame_ready` 1 and `tx_busy` 0) in the cycle after the edge that samples `stop_req` low.
- R10: `start_permit` is never 1 while `tx_busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stop_req | input | 1 | Software pause request level |
| tx_busy | input | 1 | Transmit engine has a frame in progress |
| tx_eof | input | 1 | One-cycle strobe: frame finished normally |
| tx_col_abort | input | 1 | One-cycle strobe: frame terminated by collision |
| frame_ready | input | 1 | Queue holds a frame ready to send |
| start_permit | output | 1 | Transmit engine may begin the next frame |
| stop_done | output | 1 | One-cycle event: pause reached |

## Verification
On every cycle, the assertions check four properties. The stop event lasts exactly one cycle and fires at most once for each request. The event appears only after a cycle that was a frame boundary. Start permission is never given during a request or during a busy frame. Only the directed scenarios can show the exact cycle of completion for each way a frame can end. They also show that a request withdrawn mid-frame leaves no event behind, and that permission returns at the right edge after a release.

// File: rtl/gts_pkg.sv
package gts_pkg;
  typedef enum logic [1:0] {
    GTS_RUN   = 2'd0,
    GTS_DRAIN = 2'd1,
    GTS_HALT  = 2'd2
  } gts_state_e;
endpackage

// File: rtl/gts_rst_sync.sv
module gts_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/gts_fsm.sv
module gts_fsm
  import gts_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_req,
  input  logic       at_boundary,
  output gts_state_e state,
  output logic       enter_halt
);
  gts_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      GTS_RUN:   if (stop_req) state_d = at_boundary ? GTS_HALT : GTS_DRAIN;
      GTS_DRAIN: begin
        if (!stop_req)        state_d = GTS_RUN;
        else if (at_boundary) state_d = GTS_HALT;
      end
      GTS_HALT:  if (!stop_req) state_d = GTS_RUN;
      default:   state_d = GTS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= GTS_RUN;
    else        state_q <= state_d;
  end

  assign state      = state_q;
  assign enter_halt = (state_d == GTS_HALT) && (state_q != GTS_HALT);
endmodule

// File: rtl/gts_pulse.sv
module gts_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  logic pulse_q, pulse_d, pulse_en;

  always_comb begin
    pulse_en = fire | pulse_q;
    pulse_d  = fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pulse_q <= 1'b0;
    else if (pulse_en) pulse_q <= pulse_d;
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/gts_ctrl.sv
module gts_ctrl
  import gts_pkg::*;
#(
  parameter int RST_SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic tx_busy,
  input  logic tx_eof,
  input  logic tx_col_abort,
  input  logic frame_ready,
  output logic start_permit,
  output logic stop_done
);
  logic       rst_n_int;
  logic       at_boundary;
  logic       enter_halt;
  gts_state_e state;

  gts_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  // A frame boundary: nothing on the wire, or the frame ends this cycle.
  assign at_boundary = !tx_busy || tx_eof || tx_col_abort;

  gts_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .stop_req    (stop_req),
    .at_boundary (at_boundary),
    .state       (state),
    .enter_halt  (enter_halt)
  );

  gts_pulse u_evt (
    .clk   (clk),
    .rst_n (rst_n_int),
    .fire  (enter_halt),
    .pulse (stop_done)
  );

  // Permission is gated directly by the request so a new request blocks
  // a start in its very first cycle.
  assign start_permit = (state == GTS_RUN) && !stop_req && frame_ready && !tx_busy;
endmodule

// File: rtl/gts_ctrl_chk.sv
module gts_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic stop_req,
  input logic tx_busy,
  input logic tx_eof,
  input logic tx_col_abort,
  input logic frame_ready,
  input logic start_permit,
  input logic stop_done
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         seen_q <= 1'b0;
    else if (!stop_req) seen_q <= 1'b0;
    else if (stop_done) seen_q <= 1'b1;
  end

  // R6
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_done |=> !stop_done);

  // R6
  done_once_per_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_done |-> !seen_q);

  // R3
  done_after_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_done |-> $past(stop_req && (!tx_busy || tx_eof || tx_col_abort)));

  // R8
  no_permit_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> !start_permit);

  // R10
  no_permit_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> !start_permit);

  // R1
  permit_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_permit |-> frame_ready);
endmodule

bind gts_ctrl gts_ctrl_chk u_chk (.*);

// File: tb/gts_ctrl_test.sv
`timescale 1ns/1ps
module gts_ctrl_test;
  logic clk = 1'b0;
  logic rst_n;
  logic stop_req, tx_busy, tx_eof, tx_col_abort, frame_ready;
  logic start_permit, stop_done;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  gts_ctrl uut (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .tx_busy(tx_busy),
    .tx_eof(tx_eof), .tx_col_abort(tx_col_abort), .frame_ready(frame_ready),
    .start_permit(start_permit), .stop_done(stop_done)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic at_neg();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; stop_req = 0; tx_busy = 0; tx_eof = 0; tx_col_abort = 0; frame_ready = 1;
    repeat (3) step();
    at_neg(); rst_n = 1'b1;
    repeat (4) step();
    check("R1", "done after reset", stop_done, 1'b0);
    check("R1", "permit after reset", start_permit, 1'b1);
    at_neg(); frame_ready = 0; #1;
    check("R1", "permit without frame", start_permit, 1'b0);
    at_neg(); frame_ready = 1; #1;
  endtask

  task automatic t_idle_stop();
    at_neg(); stop_req = 1; #1;
    check("R8", "permit in request cycle", start_permit, 1'b0);
    step();
    check("R2", "idle stop event", stop_done, 1'b1);
    step();
    check("R6", "event one cycle", stop_done, 1'b0);
    for (int i = 0; i < 5; i++) begin
      step();
      check("R6", "no repeat event", stop_done, 1'b0);
    end
    at_neg(); stop_req = 0; #1;
    check("R9", "permit before release edge", start_permit, 1'b0);
    step();
    check("R9", "permit after release", start_permit, 1'b1);
  endtask

  task automatic t_end_stop(input bit use_col);
    string rq;
    rq = use_col ? "R5" : "R4";
    at_neg(); tx_busy = 1; #1;
    check("R10", "permit while busy", start_permit, 1'b0);
    at_neg(); stop_req = 1;
    for (int i = 0; i < 3; i++) begin
      step();
      check("R3", "no event mid-frame", stop_done, 1'b0);
      check("R3", "no permit mid-frame", start_permit, 1'b0);
    end
    at_neg(); if (use_col) tx_col_abort = 1; else tx_eof = 1;
    step();
    check(rq, "event after frame end", stop_done, 1'b1);
    at_neg(); tx_busy = 0; tx_eof = 0; tx_col_abort = 0;
    step();
    check("R6", "event one cycle", stop_done, 1'b0);
    at_neg(); stop_req = 0;
    step();
    check("R9", "permit resumes", start_permit, 1'b1);
  endtask

  task automatic t_cancel();
    at_neg(); tx_busy = 1; stop_req = 1;
    step(); step();
    check("R7", "no event while pending", stop_done, 1'b0);
    at_neg(); stop_req = 0;
    step();
    check("R7", "no event after cancel", stop_done, 1'b0);
    at_neg(); tx_eof = 1;
    step();
    check("R7", "no event at frame end", stop_done, 1'b0);
    at_neg(); tx_eof = 0; tx_busy = 0; #1;
    check("R7", "permit after cancelled stop", start_permit, 1'b1);
    step();
    check("R7", "still no event", stop_done, 1'b0);
  endtask

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_idle_stop();
    t_end_stop(1'b0);
    t_end_stop(1'b1);
    t_cancel();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule